// File: doc/BRIEF.md
# Shadowed SRAM Recall Controller

This block models a small static RAM that has a nonvolatile shadow copy behind it, together with the sequencer that moves data between the two arrays. A host reaches the RAM through a plain synchronous port with chip enable and write enable. Two digital supply-status inputs come from an external monitor. One says the supply has dropped below the reset level. The other says the supply is above the switch level.

A supply dip latches a request to restore the RAM from the shadow array. Reset counts as such a dip. The restore starts by itself once the supply is good again. It runs in two phases: first it zeroes every RAM word, then it copies every shadow word into the RAM. A store request copies the RAM into the shadow array. Stores are only accepted while the supply is good and no restore is waiting. Both operations step one address per clock and raise `busy` for their whole length.

Top module: `shadow_sram_ctl`

## Requirements
- R1: While `busy` is low, a cycle with `mem_ce`=1 and `mem_we`=1 writes `mem_wdata` to `mem_addr`. A cycle with `mem_ce`=1 and `mem_we`=0 puts that word on `mem_rdata` after the next clock edge. `mem_rdata` holds its value otherwise.
- R2: Reset latches a recall request. A latched request starts on the first edge where `vdd_above_switch`=1 and `vdd_below_reset`=0. `busy` is then high for exactly 2×DEPTH cycles.
- R3: A recall first zeroes RAM words 0 to DEPTH-1 in ascending order, one per cycle. It then copies shadow words 0 to DEPTH-1 into the RAM in the same order. It never changes the shadow array, so repeated recalls return the same contents.
- R4: Any cycle with `vdd_below_reset`=1 latches a recall request, which stays latched until a recall starts. No operation starts while `vdd_above_switch`=0.
- R5: A store request accepted in idle copies every RAM word into the shadow array, one address per cycle. `busy` is high for exactly DEPTH cycles.
- R6: `store_req` is ignored while `vdd_above_switch`=0. `busy` stays low and the shadow array keeps its contents.
- R7: `store_req` is ignored while a recall request is latched or `vdd_below_reset`=1.
- R8: While `busy` is high, host reads and writes are not serviced and `mem_rdata` holds its value.
- R9: `vdd_below_reset`=1 during a recall aborts it on that edge, so `busy` is low in the next cycle. The abort leaves the RAM partly processed and re-latches the request. The next recall runs the full 2×DEPTH cycles, starting from the zeroing phase.
- R10: `data_corrupt` is set if `mem_ce`=1 and `mem_we`=1 in the last cycle of a recall that runs to completion. It is cleared when the next recall starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_ce | input | 1 | Chip enable of the host port |
| mem_we | input | 1 | Write enable of the host port |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | 8 | Write data |
| mem_rdata | output | 8 | Registered read data |
| vdd_below_reset | input | 1 | Supply is under the reset level |
| vdd_above_switch | input | 1 | Supply is over the switch level |
| store_req | input | 1 | Request to copy the RAM into the shadow array |
| busy | output | 1 | A recall or store is running |
| data_corrupt | output | 1 | A write was active as a recall finished |

## Verification
The RAM state inside an aborted recall is the hardest thing to reach from the ports, because the host cannot read the RAM while a recall runs. The bench counts `busy` cycles after a recall starts. It raises `vdd_below_reset` at a chosen count, once in the zeroing phase and once in the copy phase. It keeps that input high so the request stays latched and no new recall starts. It then reads every word through the idle host port and checks the exact boundary between zeroed, copied and untouched words.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
// Shared types of the shadowed SRAM controller.
// Assumes: nothing beyond IEEE 1800-2017.
package nvs_pkg;

    // Sequencer phase: idle, recall zeroing, recall copy, store copy.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_COPY  = 2'd2,
        PH_STORE = 2'd3
    } nvs_phase_e;

endpackage

// File: rtl/nvs_array.sv
`timescale 1ns/1ps
// Word array with one synchronous write port and one combinational read port.
// Used for both the volatile RAM and the shadow copy.
// Assumes: writes and reads never need the same-cycle bypass, and a reset clears every word.
module nvs_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Clear every word on reset, otherwise apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Asynchronous read of the addressed word.
    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/nvs_seq.sv
`timescale 1ns/1ps
// Recall/store sequencer. It holds the latched recall request, the phase and the
// address index, and the corruption flag.
// Assumes: the supply inputs are already synchronous to clk; one address per cycle.
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sup_low,
    input  logic          sup_ok,
    input  logic          store_req,
    input  logic          ce,
    input  logic          we,
    output nvs_phase_e    phase,
    output logic [AW-1:0] idx,
    output logic          pend_q,
    output logic          busy,
    output logic          corrupt
);
    localparam logic [AW-1:0] LAST_IDX = '1;

    logic at_last;
    logic start_recall;
    logic start_store;

    // Decode of the end-of-sweep address.
    assign at_last      = (idx == LAST_IDX);
    // A latched request starts once the supply is good and no dip is present.
    assign start_recall = (phase == PH_IDLE) && pend_q && sup_ok && !sup_low;
    // A store needs a good supply, no dip and no waiting recall.
    assign start_store  = (phase == PH_IDLE) && !pend_q && sup_ok && !sup_low && store_req;
    // Any non-idle phase is reported as busy.
    assign busy         = (phase != PH_IDLE);

    // Request latch: a dip sets it, a recall start consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b1;
        end else if (sup_low) begin
            pend_q <= 1'b1;
        end else if (start_recall) begin
            pend_q <= 1'b0;
        end
    end

    // Phase, index and corruption flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            idx     <= '0;
            corrupt <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    idx <= '0;
                    if (start_recall) begin
                        phase   <= PH_CLEAR;
                        corrupt <= 1'b0;
                    end else if (start_store) begin
                        phase <= PH_STORE;
                    end
                end
                PH_CLEAR: begin
                    if (sup_low) begin
                        phase <= PH_IDLE;
                        idx   <= '0;
                    end else if (at_last) begin
                        phase <= PH_COPY;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_COPY: begin
                    if (sup_low) begin
                        phase <= PH_IDLE;
                        idx   <= '0;
                    end else if (at_last) begin
                        phase   <= PH_IDLE;
                        idx     <= '0;
                        corrupt <= ce && we;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: begin
                    if (at_last) begin
                        phase <= PH_IDLE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/shadow_sram_ctl.sv
`timescale 1ns/1ps
// Static RAM with a nonvolatile shadow array. A supply dip or reset latches a
// recall (zero the RAM, then copy the shadow into it). A store copies the RAM into the shadow.
// Assumes: synchronous supply-status inputs; host accesses are only serviced in idle.
module shadow_sram_ctl
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_ce,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_rdata,
    input  logic              vdd_below_reset,
    input  logic              vdd_above_switch,
    input  logic              store_req,
    output logic              busy,
    output logic              data_corrupt
);
    nvs_phase_e        phase;
    logic [ADDR_W-1:0] idx;
    logic              pend_q;
    logic              idle;
    logic              recall_wr;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_wa;
    logic [DATA_W-1:0] ram_wd;
    logic [ADDR_W-1:0] ram_ra;
    logic [DATA_W-1:0] ram_rd;
    logic              shd_we;
    logic [DATA_W-1:0] shd_rd;

    nvs_seq #(.AW(ADDR_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sup_low   (vdd_below_reset),
        .sup_ok    (vdd_above_switch),
        .store_req (store_req),
        .ce        (mem_ce),
        .we        (mem_we),
        .phase     (phase),
        .idx       (idx),
        .pend_q    (pend_q),
        .busy      (busy),
        .corrupt   (data_corrupt)
    );

    // Idle decode and recall write enable (an aborting dip suppresses the write).
    assign idle      = (phase == PH_IDLE);
    assign recall_wr = ((phase == PH_CLEAR) || (phase == PH_COPY)) && !vdd_below_reset;

    // RAM port steering: the host in idle, the sequencer otherwise.
    always_comb begin
        ram_we = recall_wr || (idle && mem_ce && mem_we);
        ram_wa = idle ? mem_addr : idx;
        ram_ra = idle ? mem_addr : idx;
        case (phase)
            PH_CLEAR: ram_wd = '0;
            PH_COPY:  ram_wd = shd_rd;
            default:  ram_wd = mem_wdata;
        endcase
    end

    // The shadow is written only during a store sweep.
    assign shd_we = (phase == PH_STORE);

    nvs_array #(.AW(ADDR_W), .DW(DATA_W)) i_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ram_we),
        .wr_addr (ram_wa),
        .wr_data (ram_wd),
        .rd_addr (ram_ra),
        .rd_data (ram_rd)
    );

    nvs_array #(.AW(ADDR_W), .DW(DATA_W)) i_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (shd_we),
        .wr_addr (idx),
        .wr_data (ram_rd),
        .rd_addr (idx),
        .rd_data (shd_rd)
    );

    // Registered host read, updated only by an idle read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rdata <= '0;
        end else if (idle && mem_ce && !mem_we) begin
            mem_rdata <= ram_rd;
        end
    end

endmodule

// File: rtl/shadow_sram_ctl_chk.sv
`timescale 1ns/1ps
// Property checker for shadow_sram_ctl, attached with bind below.
// Assumes: observes only, drives nothing.
module shadow_sram_ctl_chk
    import nvs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              we,
    input logic              sup_low,
    input logic              sup_ok,
    input logic              store_req,
    input logic              busy,
    input logic              corrupt,
    input logic [DATA_W-1:0] rdata,
    input logic              pend_q,
    input nvs_phase_e        phase
);
    // R4: nothing starts while the supply is under the switch level.
    a_r4_no_start_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sup_ok) |=> !busy);

    // R4: a dip always leaves a latched request.
    a_r4_dip_latches: assert property (@(posedge clk) disable iff (!rst_n)
        sup_low |=> pend_q);

    // R6: a store request under a bad supply does not start anything.
    a_r6_store_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && store_req && !sup_ok) |=> !busy);

    // R7: no store starts while a recall is waiting.
    a_r7_store_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pend_q && store_req) |=> (phase != PH_STORE));

    // R8: host read data is frozen while an operation runs.
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rdata));

    // R9: a dip inside a recall ends it on that edge.
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (((phase == PH_CLEAR) || (phase == PH_COPY)) && sup_low) |=> !busy);

    // R10: the corruption flag only rises as a recall copy finishes.
    a_r10_corrupt_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(corrupt) |-> ($past(phase) == PH_COPY));

endmodule

bind shadow_sram_ctl shadow_sram_ctl_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (mem_ce),
    .we        (mem_we),
    .sup_low   (vdd_below_reset),
    .sup_ok    (vdd_above_switch),
    .store_req (store_req),
    .busy      (busy),
    .corrupt   (data_corrupt),
    .rdata     (mem_rdata),
    .pend_q    (pend_q),
    .phase     (phase)
);

// File: tb/test_shadow_sram_ctl.sv
`timescale 1ns/1ps
module test_shadow_sram_ctl;
    localparam int AW = 4;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce, we, sup_low, sup_ok, store_req;
    logic [AW-1:0] addr;
    logic [7:0]    wdata;
    logic [7:0]    rdata;
    logic          busy, corrupt;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #10 clk = ~clk;

    shadow_sram_ctl #(.ADDR_W(AW), .DATA_W(8)) i_shadow_sram_ctl (
        .clk              (clk),
        .rst_n            (rst_n),
        .mem_ce           (ce),
        .mem_we           (we),
        .mem_addr         (addr),
        .mem_wdata        (wdata),
        .mem_rdata        (rdata),
        .vdd_below_reset  (sup_low),
        .vdd_above_switch (sup_ok),
        .store_req        (store_req),
        .busy             (busy),
        .data_corrupt     (corrupt)
    );

    function automatic logic [7:0] pat_p(input int a);
        return 8'(a * 7 + 3);
    endfunction

    function automatic logic [7:0] pat_q(input int a);
        return 8'(a * 13 + 100);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        ce = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        ce = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk);
        ce = 1'b1; we = 1'b0; addr = AW'(a);
        @(negedge clk);
        v = rdata;
        ce = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
    endtask

    task automatic dip_pulse();
        @(negedge clk);
        sup_low = 1'b1;
        @(negedge clk);
        sup_low = 1'b0;
    endtask

    task automatic check_all(input string req, input int mode, input int split);
        logic [7:0] v;
        logic [7:0] e;
        for (int a = 0; a < D; a++) begin
            rd(a, v);
            case (mode)
                0: e = pat_p(a);
                1: e = 8'd0;
                2: e = (a < split) ? 8'd0 : pat_q(a);
                default: e = (a < split) ? pat_p(a) : 8'd0;
            endcase
            check(v == e, req, v, e);
        end
    endtask

    task automatic abort_at(input int m);
        int n;
        @(negedge clk);
        sup_low = 1'b1;
        @(negedge clk);
        sup_low = 1'b0;
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (busy) n++;
            if (n == m) begin
                sup_low = 1'b1;
                break;
            end
        end
        @(negedge clk);
        check(busy == 1'b0, "R9 abort ends recall", busy, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, n0;
        logic [7:0] v, held;
        bit ok;
        rst_n = 1'b0; ce = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        sup_low = 1'b1; sup_ok = 1'b0; store_req = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && rdata == 8'd0 && corrupt == 1'b0, "R2 reset state", busy, 0);
        rst_n = 1'b1;
        // R4: dip held and supply low: no recall starts.
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R4 held during dip", busy, 0);
        sup_low = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R4 waits for switch level", busy, 0);
        sup_ok = 1'b1;
        count_busy(n);
        check(n == 2 * D, "R2 recall length", n, 2 * D);
        check_all("R3 recall of empty shadow", 1, 0);

        // R1: write and read every address.
        for (int a = 0; a < D; a++) wr(a, pat_p(a));
        check_all("R1 write/read", 0, 0);

        // R5: store copies the RAM into the shadow.
        @(negedge clk); store_req = 1'b1;
        @(negedge clk); store_req = 1'b0;
        n0 = busy ? 1 : 0;
        count_busy(n);
        check(n0 + n == D, "R5 store length", n0 + n, D);

        // R6: store under low supply is ignored.
        for (int a = 0; a < D; a++) wr(a, pat_q(a));
        @(negedge clk); sup_ok = 1'b0; store_req = 1'b1;
        @(negedge clk); store_req = 1'b0;
        check(busy == 1'b0, "R6 store ignored busy", busy, 0);
        @(negedge clk);
        check(busy == 1'b0, "R6 store ignored busy later", busy, 0);
        sup_ok = 1'b1;

        // R7: store while a recall is latched is ignored.
        @(negedge clk); sup_low = 1'b1;
        @(negedge clk); store_req = 1'b1;
        @(negedge clk); store_req = 1'b0;
        check(busy == 1'b0, "R7 store refused", busy, 0);
        sup_low = 1'b0;
        count_busy(n);
        check(n == 2 * D, "R4 latched request serviced", n, 2 * D);
        check_all("R3 R6 R7 shadow holds stored image", 0, 0);

        // R8: host access is frozen during a recall.
        rd(2, held);
        dip_pulse();
        n = 0; ok = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (!busy) break;
            n++;
            if (rdata != held) ok = 1'b0;
            ce = 1'b1; we = n[0]; addr = AW'(9); wdata = 8'hEE;
        end
        ce = 1'b0; we = 1'b0;
        check(ok, "R8 rdata held", rdata, held);
        rd(9, v);
        check(v == pat_p(9), "R8 write ignored", v, pat_p(9));

        // R9: abort in zeroing phase, then in copy phase.
        for (int a = 0; a < D; a++) wr(a, pat_q(a));
        abort_at(6);
        check_all("R9 R3 abort while zeroing", 2, 5);
        abort_at(D + 5);
        check_all("R9 R3 abort while copying", 3, 4);
        @(negedge clk); sup_low = 1'b0;
        count_busy(n);
        check(n == 2 * D, "R9 restart full length", n, 2 * D);
        check_all("R9 restart contents", 0, 0);

        // R10: write active in the last recall cycle.
        dip_pulse();
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (!busy) break;
            n++;
            if (n == 2 * D) begin
                ce = 1'b1; we = 1'b1; addr = '0; wdata = 8'h55;
            end
        end
        ce = 1'b0; we = 1'b0;
        check(corrupt == 1'b1, "R10 flag set", corrupt, 1);
        rd(0, v);
        check(v == pat_p(0), "R8 final-cycle write ignored", v, pat_p(0));
        dip_pulse();
        @(negedge clk);
        check(corrupt == 1'b0 && busy == 1'b1, "R10 flag cleared at start", corrupt, 0);
        count_busy(n);
        check(corrupt == 1'b0, "R10 clean recall", corrupt, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule